// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits on the host side of a bridge and keeps six programmable address windows: a configuration-space window, a message window, three outbound windows and an internal-register window. Software programs each window's 64-bit base and its mask over a small word-addressed register bus. Every 64-bit quantity is split into a low word and a high word that are written one at a time. The block also keeps one scratch word for software that plays no part in decoding.

Addresses to be decoded arrive on a valid/ready stream. For each accepted address the block returns one result beat on a second valid/ready stream. The beat says whether the address falls inside an enabled window, which window matched, and the offset from that window's base. A window's size comes from its mask: bit 0 of the mask turns the window on, and the size is the two's complement of the mask with bit 0 forced to zero.

The configuration window's size is limited to a parameterised ceiling. The internal-register window treats one particular mask value as a fixed 4 KiB window. The block only decodes; moving the transactions themselves is left to other logic.

Top module: `awd_decoder`

## Requirements
- R1: After reset every window is disabled, every register reads zero, `reg_rdata` is zero, and `rs_valid` is low.
- R2: For each 64-bit base or mask, writing the low word keeps the high word and writing the high word keeps the low word. A read returns the addressed word on `reg_rdata` one cycle after `reg_rd_en`, and `reg_rdata` changes only on a read strobe. Word offsets inside the block are: 0 scratch, 1 register-window mask, 2/3 register-window base low/high, 4 config mask, 5/6 config base low/high, 7 message mask, 8/9 message base low/high, and for outbound window n (0..2) offsets 12+4n / 13+4n for base low/high and 14+4n / 15+4n for mask low/high.
- R3: The config window is enabled by bit 0 of its 32-bit mask. Its size is S = (2^32 - (mask with bit 0 cleared)) mod 2^32. An address A hits when base <= A < base+S, and the reported offset is A - base.
- R4: When the config size S exceeds CFG_SIZE_MAX, CFG_SIZE_MAX is used as the size instead.
- R5: The message window uses a 64-bit base and a 32-bit mask, with the same enable and size rule as R3 and no ceiling.
- R6: Each outbound window uses a 64-bit base and a 64-bit mask. It is enabled by bit 0 of the mask's low word, and its size is (2^64 - (mask with bit 0 cleared)) mod 2^64.
- R7: The internal-register window uses a 32-bit mask. The value 0x00007001 gives an enabled 4096-byte window; any other value follows the rule of R3.
- R8: When several windows hit, the result names the first in this order: config (code 0), message (1), outbound 0..2 (2..4), register window (5).
- R9: The scratch word at offset 0 reads back what was written and has no effect on any decode.
- R10: The register block answers only to the 32 addresses starting at BLOCK_BASE, and only when BLOCK_BASE is 0x100 or 0x120. Writes elsewhere change nothing, and reads elsewhere return zero.
- R11: `lk_ready` is high exactly when no result is held or the held result is being taken. A result beat stays stable while `rs_valid` is high and `rs_ready` is low, and each accepted lookup produces a result beat in the next cycle.
- R12: A lookup that hits no window returns `rs_hit`=0, `rs_win`=0 and `rs_offset`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | REG_ADDR_W | Register word address on the shared register bus |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| lk_valid | input | 1 | Lookup address valid |
| lk_ready | output | 1 | Lookup address accepted when high with lk_valid |
| lk_addr | input | 64 | Address to decode |
| rs_valid | output | 1 | Result beat valid |
| rs_ready | input | 1 | Consumer takes the result beat |
| rs_hit | output | 1 | Address fell in an enabled window |
| rs_win | output | 3 | Code of the matching window (R8) |
| rs_offset | output | 64 | Address minus the matching window's base |

## Verification
The assertions assume the consumer follows valid/ready: a lookup counts as taken only in a cycle where both lk_valid and lk_ready are high, and the bus strobes are never X once reset is released. The stimulus changes every input on the falling edge and holds lk_valid and lk_addr until the handshake completes. Stalls come only from the bench dropping rs_ready, which is how the hold rule of R11 is exercised. Register writes and lookups never share an edge, so a decode always sees settled window registers.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int unsigned NUM_OB    = 3;
  localparam int unsigned NUM_WIN   = NUM_OB + 3;
  localparam int unsigned WIN_IDX_W = 3;

  typedef enum logic [WIN_IDX_W-1:0] {
    WIN_CFG = 3'd0,
    WIN_MSG = 3'd1,
    WIN_OB0 = 3'd2,
    WIN_OB1 = 3'd3,
    WIN_OB2 = 3'd4,
    WIN_RGW = 3'd5
  } win_id_e;

  localparam logic [4:0] OFS_SCRATCH  = 5'd0;
  localparam logic [4:0] OFS_RGW_MASK = 5'd1;
  localparam logic [4:0] OFS_RGW_LO   = 5'd2;
  localparam logic [4:0] OFS_RGW_HI   = 5'd3;
  localparam logic [4:0] OFS_CFG_MASK = 5'd4;
  localparam logic [4:0] OFS_CFG_LO   = 5'd5;
  localparam logic [4:0] OFS_CFG_HI   = 5'd6;
  localparam logic [4:0] OFS_MSG_MASK = 5'd7;
  localparam logic [4:0] OFS_MSG_LO   = 5'd8;
  localparam logic [4:0] OFS_MSG_HI   = 5'd9;
  localparam int unsigned OFS_OB_FIRST = 12;

  localparam logic [31:0] RGW_FIXED_CODE = 32'h0000_7001;
  localparam logic [63:0] RGW_FIXED_SIZE = 64'd4096;

  function automatic logic [63:0] span_of_mask32(input logic [31:0] m);
    logic [31:0] t;
    t = (~(m & 32'hFFFF_FFFE)) + 32'd1;
    return {32'd0, t};
  endfunction

  function automatic logic [63:0] span_of_mask64(input logic [63:0] m);
    return (~(m & 64'hFFFF_FFFF_FFFF_FFFE)) + 64'd1;
  endfunction
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int unsigned            REG_ADDR_W = 10,
  parameter logic [REG_ADDR_W-1:0]  BLOCK_BASE = 10'h100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [REG_ADDR_W-1:0]   addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  output logic [63:0]             cfg_base,
  output logic [31:0]             cfg_mask,
  output logic [63:0]             msg_base,
  output logic [31:0]             msg_mask,
  output logic [NUM_OB-1:0][63:0] ob_base,
  output logic [NUM_OB-1:0][63:0] ob_mask,
  output logic [63:0]             rgw_base,
  output logic [31:0]             rgw_mask
);
  localparam bit BASE_OK = (BLOCK_BASE == REG_ADDR_W'(10'h100)) ||
                           (BLOCK_BASE == REG_ADDR_W'(10'h120));

  logic        in_block;
  logic [4:0]  ofs;
  logic        wr_hit;
  logic [31:0] scratch;
  logic [31:0] rd_mux;

  assign ofs      = addr[4:0];
  assign in_block = BASE_OK && (addr[REG_ADDR_W-1:5] == BLOCK_BASE[REG_ADDR_W-1:5]);
  assign wr_hit   = wr_en && in_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch  <= '0;
      cfg_base <= '0;
      cfg_mask <= '0;
      msg_base <= '0;
      msg_mask <= '0;
      rgw_base <= '0;
      rgw_mask <= '0;
    end else if (wr_hit) begin
      case (ofs)
        OFS_SCRATCH:  scratch         <= wdata;
        OFS_RGW_MASK: rgw_mask        <= wdata;
        OFS_RGW_LO:   rgw_base[31:0]  <= wdata;
        OFS_RGW_HI:   rgw_base[63:32] <= wdata;
        OFS_CFG_MASK: cfg_mask        <= wdata;
        OFS_CFG_LO:   cfg_base[31:0]  <= wdata;
        OFS_CFG_HI:   cfg_base[63:32] <= wdata;
        OFS_MSG_MASK: msg_mask        <= wdata;
        OFS_MSG_LO:   msg_base[31:0]  <= wdata;
        OFS_MSG_HI:   msg_base[63:32] <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar n = 0; n < NUM_OB; n++) begin : g_ob
    localparam logic [4:0] O_BLO = 5'(OFS_OB_FIRST + 4 * n);
    localparam logic [4:0] O_BHI = 5'(OFS_OB_FIRST + 4 * n + 1);
    localparam logic [4:0] O_MLO = 5'(OFS_OB_FIRST + 4 * n + 2);
    localparam logic [4:0] O_MHI = 5'(OFS_OB_FIRST + 4 * n + 3);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ob_base[n] <= '0;
        ob_mask[n] <= '0;
      end else if (wr_hit) begin
        if (ofs == O_BLO) ob_base[n][31:0]  <= wdata;
        if (ofs == O_BHI) ob_base[n][63:32] <= wdata;
        if (ofs == O_MLO) ob_mask[n][31:0]  <= wdata;
        if (ofs == O_MHI) ob_mask[n][63:32] <= wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (ofs)
      OFS_SCRATCH:  rd_mux = scratch;
      OFS_RGW_MASK: rd_mux = rgw_mask;
      OFS_RGW_LO:   rd_mux = rgw_base[31:0];
      OFS_RGW_HI:   rd_mux = rgw_base[63:32];
      OFS_CFG_MASK: rd_mux = cfg_mask;
      OFS_CFG_LO:   rd_mux = cfg_base[31:0];
      OFS_CFG_HI:   rd_mux = cfg_base[63:32];
      OFS_MSG_MASK: rd_mux = msg_mask;
      OFS_MSG_LO:   rd_mux = msg_base[31:0];
      OFS_MSG_HI:   rd_mux = msg_base[63:32];
      default:      rd_mux = '0;
    endcase
    for (int n = 0; n < NUM_OB; n++) begin
      if (ofs == 5'(OFS_OB_FIRST + 4 * n))     rd_mux = ob_base[n][31:0];
      if (ofs == 5'(OFS_OB_FIRST + 4 * n + 1)) rd_mux = ob_base[n][63:32];
      if (ofs == 5'(OFS_OB_FIRST + 4 * n + 2)) rd_mux = ob_mask[n][31:0];
      if (ofs == 5'(OFS_OB_FIRST + 4 * n + 3)) rd_mux = ob_mask[n][63:32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= in_block ? rd_mux : 32'd0;
  end
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match #(
  parameter int unsigned AW = 64
) (
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] span,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] offset
);
  logic [AW-1:0] delta;

  assign delta  = addr - base;
  assign hit    = en && (addr >= base) && (delta < span);
  assign offset = delta;
endmodule

// File: rtl/awd_prio_pick.sv
module awd_prio_pick #(
  parameter int unsigned N     = 6,
  parameter int unsigned AW    = 64,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]         hits,
  input  logic [N-1:0][AW-1:0] offsets,
  output logic                 any,
  output logic [IDX_W-1:0]     idx,
  output logic [AW-1:0]        offset
);
  always_comb begin
    any    = |hits;
    idx    = '0;
    offset = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        idx    = IDX_W'(i);
        offset = offsets[i];
      end
    end
  end
endmodule

// File: rtl/awd_decoder.sv
module awd_decoder
  import awd_pkg::*;
#(
  parameter int unsigned           REG_ADDR_W   = 10,
  parameter logic [REG_ADDR_W-1:0] BLOCK_BASE   = 10'h100,
  parameter logic [63:0]           CFG_SIZE_MAX = 64'h0000_0000_1000_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_en,
  input  logic                  reg_rd_en,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  lk_valid,
  output logic                  lk_ready,
  input  logic [63:0]           lk_addr,
  output logic                  rs_valid,
  input  logic                  rs_ready,
  output logic                  rs_hit,
  output logic [2:0]            rs_win,
  output logic [63:0]           rs_offset
);
  logic [63:0]             cfg_base, msg_base, rgw_base;
  logic [31:0]             cfg_mask, msg_mask, rgw_mask;
  logic [NUM_OB-1:0][63:0] ob_base, ob_mask;

  awd_regfile #(.REG_ADDR_W(REG_ADDR_W), .BLOCK_BASE(BLOCK_BASE)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .cfg_base(cfg_base), .cfg_mask(cfg_mask),
    .msg_base(msg_base), .msg_mask(msg_mask),
    .ob_base(ob_base), .ob_mask(ob_mask),
    .rgw_base(rgw_base), .rgw_mask(rgw_mask)
  );

  logic [NUM_WIN-1:0]       win_en;
  logic [NUM_WIN-1:0][63:0] win_base;
  logic [NUM_WIN-1:0][63:0] win_span;
  logic [NUM_WIN-1:0]       win_hit;
  logic [NUM_WIN-1:0][63:0] win_off;
  logic [63:0]              cfg_raw_span;

  assign cfg_raw_span = span_of_mask32(cfg_mask);

  always_comb begin
    win_en[WIN_CFG]   = cfg_mask[0];
    win_base[WIN_CFG] = cfg_base;
    win_span[WIN_CFG] = (cfg_raw_span > CFG_SIZE_MAX) ? CFG_SIZE_MAX : cfg_raw_span;

    win_en[WIN_MSG]   = msg_mask[0];
    win_base[WIN_MSG] = msg_base;
    win_span[WIN_MSG] = span_of_mask32(msg_mask);

    for (int n = 0; n < NUM_OB; n++) begin
      win_en[WIN_OB0 + n]   = ob_mask[n][0];
      win_base[WIN_OB0 + n] = ob_base[n];
      win_span[WIN_OB0 + n] = span_of_mask64(ob_mask[n]);
    end

    win_en[WIN_RGW]   = rgw_mask[0];
    win_base[WIN_RGW] = rgw_base;
    win_span[WIN_RGW] = (rgw_mask == RGW_FIXED_CODE) ? RGW_FIXED_SIZE
                                                     : span_of_mask32(rgw_mask);
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    awd_win_match #(.AW(64)) match_i (
      .en(win_en[w]), .base(win_base[w]), .span(win_span[w]),
      .addr(lk_addr), .hit(win_hit[w]), .offset(win_off[w])
    );
  end

  logic                 pick_any;
  logic [WIN_IDX_W-1:0] pick_idx;
  logic [63:0]          pick_off;

  awd_prio_pick #(.N(NUM_WIN), .AW(64), .IDX_W(WIN_IDX_W)) pick_i (
    .hits(win_hit), .offsets(win_off),
    .any(pick_any), .idx(pick_idx), .offset(pick_off)
  );

  logic take;
  assign lk_ready = !rs_valid || rs_ready;
  assign take     = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid  <= 1'b0;
      rs_hit    <= 1'b0;
      rs_win    <= '0;
      rs_offset <= '0;
    end else if (take) begin
      rs_valid  <= 1'b1;
      rs_hit    <= pick_any;
      rs_win    <= pick_idx;
      rs_offset <= pick_off;
    end else if (rs_ready) begin
      rs_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/awd_decoder_chk.sv
module awd_decoder_chk #(
  parameter logic [63:0] CFG_SIZE_MAX = 64'h0000_0000_1000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_rd_en,
  input logic [31:0] reg_rdata,
  input logic        lk_valid,
  input logic        lk_ready,
  input logic        rs_valid,
  input logic        rs_ready,
  input logic        rs_hit,
  input logic [2:0]  rs_win,
  input logic [63:0] rs_offset
);
  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (!rs_valid && reg_rdata == 32'd0); // R1
    end
  end

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(reg_rdata)); // R2

  AST_CFG_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_hit && rs_win == 3'd0 |-> rs_offset < CFG_SIZE_MAX); // R4

  AST_WIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_hit |-> rs_win <= 3'd5); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_hit) && $stable(rs_win) && $stable(rs_offset)); // R11

  AST_ACCEPT_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> rs_valid); // R11

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_hit |-> rs_win == 3'd0 && rs_offset == 64'd0); // R12
endmodule

bind awd_decoder awd_decoder_chk #(.CFG_SIZE_MAX(CFG_SIZE_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .rs_valid(rs_valid),
  .rs_ready(rs_ready), .rs_hit(rs_hit), .rs_win(rs_win), .rs_offset(rs_offset)
);

// File: tb/awd_decoder_tb.sv
module awd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0]  BASE   = 10'h100;
  localparam logic [63:0] CFGMAX = 64'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0, lk_ready;
  logic [63:0] lk_addr = '0;
  logic        rs_valid, rs_ready = 1'b1, rs_hit;
  logic [2:0]  rs_win;
  logic [63:0] rs_offset;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  awd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_hit(rs_hit),
    .rs_win(rs_win), .rs_offset(rs_offset)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_word [32];
  logic [31:0] m_rdata;
  logic        m_valid, m_hit;
  logic [2:0]  m_win;
  logic [63:0] m_off;

  function automatic logic [63:0] wide(input int lo_i, input int hi_i);
    return {m_word[hi_i], m_word[lo_i]};
  endfunction

  function automatic logic [63:0] span32(input logic [31:0] m);
    logic [63:0] t;
    t = 64'h1_0000_0000 - {32'd0, m & 32'hFFFF_FFFE};
    return {32'd0, t[31:0]};
  endfunction

  function automatic logic [63:0] span64(input logic [63:0] m);
    return 64'd0 - (m & ~64'd1);
  endfunction

  task automatic model_decode(input logic [63:0] a, output logic h,
                              output logic [2:0] w, output logic [63:0] o);
    logic [63:0] b [6];
    logic [63:0] s [6];
    logic        e [6];
    b[0] = wide(5, 6);  s[0] = span32(m_word[4]);  e[0] = m_word[4][0];
    if (s[0] > CFGMAX) s[0] = CFGMAX;
    b[1] = wide(8, 9);  s[1] = span32(m_word[7]);  e[1] = m_word[7][0];
    for (int n = 0; n < 3; n++) begin
      b[2+n] = wide(12 + 4*n, 13 + 4*n);
      s[2+n] = span64(wide(14 + 4*n, 15 + 4*n));
      e[2+n] = m_word[14 + 4*n][0];
    end
    b[5] = wide(2, 3);
    e[5] = m_word[1][0];
    s[5] = (m_word[1] == 32'h7001) ? 64'd4096 : span32(m_word[1]);
    h = 0; w = 0; o = 0;
    for (int i = 0; i < 6; i++) begin
      if (!h && e[i] && a >= b[i] && (a - b[i]) < s[i]) begin
        h = 1; w = 3'(i); o = a - b[i];
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_word[i] <= '0;
      m_rdata <= '0; m_valid <= 0; m_hit <= 0; m_win <= 0; m_off <= 0;
    end else begin
      logic h; logic [2:0] w; logic [63:0] o;
      logic inb;
      inb = (reg_addr >> 5) == (BASE >> 5);
      if (reg_wr_en && inb) m_word[reg_addr[4:0]] <= reg_wdata;
      if (reg_rd_en) m_rdata <= (inb && reg_addr[4:0] <= 5'd23 &&
                                 reg_addr[4:0] != 5'd10 && reg_addr[4:0] != 5'd11)
                                ? m_word[reg_addr[4:0]] : 32'd0;
      if (lk_valid && (!m_valid || rs_ready)) begin
        model_decode(lk_addr, h, w, o);
        m_valid <= 1; m_hit <= h; m_win <= w; m_off <= o;
      end else if (rs_ready) m_valid <= 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (reg_rdata !== m_rdata) begin
        failures++;
        $display("FAIL R2 model rdata act=%h exp=%h", reg_rdata, m_rdata);
      end
      checks++;
      if (lk_ready !== (!m_valid || rs_ready) || rs_valid !== m_valid ||
          (m_valid && (rs_hit !== m_hit || rs_win !== m_win || rs_offset !== m_off))) begin
        failures++;
        $display("FAIL R8 model beat act=%b/%b/%0d/%h exp=%b/%b/%0d/%h",
                 rs_valid, rs_hit, rs_win, rs_offset, m_valid, m_hit, m_win, m_off);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ofs, input logic [31:0] d, input logic [9:0] base = BASE);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = base + 10'(ofs); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(input int ofs, output logic [31:0] d, input logic [9:0] base = BASE);
    @(negedge clk);
    reg_rd_en = 1; reg_addr = base + 10'(ofs);
    @(negedge clk);
    reg_rd_en = 0;
    d = reg_rdata;
  endtask

  task automatic look(input string tag, input logic [63:0] a, input logic eh,
                      input logic [2:0] ew, input logic [63:0] eo);
    @(negedge clk);
    lk_valid = 1; lk_addr = a;
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_valid = 0;
    check({tag, " valid"}, 64'(rs_valid), 64'd1);
    check({tag, " hit"}, 64'(rs_hit), 64'(eh));
    check({tag, " win"}, 64'(rs_win), 64'(ew));
    check({tag, " offset"}, rs_offset, eo);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R1 rs_valid in reset", 64'(rs_valid), 64'd0);
    rst_n = 1;
    rd(4, d); check("R1 cfg mask after reset", 64'(d), 64'd0);
    look("R1 R12 reset miss", 64'h0, 0, 0, 0);

    // R2 halves
    wr(6, 32'h1); wr(5, 32'h8000_0000);
    rd(6, d); check("R2 cfg hi", 64'(d), 64'h1);
    wr(6, 32'h2);
    rd(5, d); check("R2 cfg lo kept", 64'(d), 64'h8000_0000);
    rd(6, d); check("R2 cfg hi new", 64'(d), 64'h2);

    // R3 config window
    wr(4, 32'hFFFF_0001);
    look("R3 inside", 64'h2_8000_1234, 1, 0, 64'h1234);
    look("R3 last byte", 64'h2_8000_FFFF, 1, 0, 64'hFFFF);
    look("R3 end", 64'h2_8001_0000, 0, 0, 0);
    look("R3 below", 64'h2_7FFF_FFFF, 0, 0, 0);
    // R4 clamp
    wr(4, 32'hE000_0001);
    look("R4 in clamp", 64'h2_8FFF_FFFF, 1, 0, 64'h0FFF_FFFF);
    look("R4 past clamp", 64'h2_9000_0000, 0, 0, 0);
    wr(4, 32'hE000_0000);
    look("R3 disabled", 64'h2_8000_0000, 0, 0, 0);

    // R5 message window
    wr(8, 32'h4000_0000); wr(7, 32'hFFFF_F001);
    look("R5 msg in", 64'h4000_0FFF, 1, 1, 64'hFFF);
    look("R5 msg end", 64'h4000_1000, 0, 0, 0);
    rd(7, d); check("R5 msg mask read", 64'(d), 64'hFFFF_F001);

    // R6 outbound window 1
    wr(17, 32'h10); wr(16, 32'h0); wr(18, 32'h1); wr(19, 32'hFFFF_FFFF);
    look("R6 ob in", 64'h10_FFFF_FFF0, 1, 3, 64'hFFFF_FFF0);
    look("R6 ob end", 64'h11_0000_0000, 0, 0, 0);
    rd(19, d); check("R6 ob mask hi", 64'(d), 64'hFFFF_FFFF);

    // R7 register window
    wr(2, 32'h5000_0000); wr(1, 32'h7001);
    look("R7 fixed in", 64'h5000_0FFF, 1, 5, 64'hFFF);
    look("R7 fixed end", 64'h5000_1000, 0, 0, 0);
    wr(1, 32'hFFFF_E001);
    look("R7 rule", 64'h5000_1000, 1, 5, 64'h1000);

    // R8 priority
    wr(20, 32'h5000_0000); wr(21, 32'h0); wr(22, 32'hFFFF_0001); wr(23, 32'hFFFF_FFFF);
    look("R8 ob over reg", 64'h5000_1000, 1, 4, 64'h1000);
    wr(8, 32'h5000_0000);
    look("R8 msg over ob", 64'h5000_0010, 1, 1, 64'h10);
    wr(6, 32'h0); wr(5, 32'h5000_0000); wr(4, 32'hFFFF_F001);
    look("R8 cfg first", 64'h5000_0010, 1, 0, 64'h10);

    // R9 scratch
    wr(0, 32'hDEAD_BEEF);
    rd(0, d); check("R9 scratch", 64'(d), 64'hDEAD_BEEF);
    look("R9 no decode effect", 64'h5000_0010, 1, 0, 64'h10);

    // R10 other block
    wr(4, 32'h0, 10'h120);
    rd(4, d); check("R10 own mask kept", 64'(d), 64'hFFFF_F001);
    rd(4, d, 10'h120); check("R10 foreign read", 64'(d), 64'h0);
    look("R10 decode kept", 64'h5000_0010, 1, 0, 64'h10);

    // R11 back-pressure, R12 miss
    @(negedge clk);
    rs_ready = 0; lk_valid = 1; lk_addr = 64'h5000_1000;
    @(negedge clk);
    lk_addr = 64'h7000_0000;
    for (int k = 0; k < 3; k++) begin
      check("R11 held valid", 64'(rs_valid), 64'd1);
      check("R11 not ready", 64'(lk_ready), 64'd0);
      check("R11 held win", 64'(rs_win), 64'd4);
      if (k < 2) @(negedge clk);
    end
    rs_ready = 1;
    @(negedge clk);
    lk_valid = 0;
    check("R11 next beat", 64'(rs_valid), 64'd1);
    check("R12 miss hit", 64'(rs_hit), 64'd0);
    check("R12 miss offset", rs_offset, 64'd0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule